// File: doc/BRIEF.md
# Byte-serial effective-address decoder

This block sits behind an instruction's opcode stage. It takes in, one byte per valid/ready handshake, the addressing bytes of a legacy variable-length instruction encoding. These are a register/memory specifier byte, an optional scaled-index byte and an optional little-endian displacement. The block works out from the specifier how many further bytes it needs. When the last byte arrives, it adds up the selected general registers, the scaled index and the displacement to form an effective address. For a register operand it names the register instead.

A width-select input picks 16-bit or 32-bit addressing rules for each instruction. The current register file is presented as one flat bus. The result appears with a one-cycle done pulse. The pulse also carries the number of addressing bytes consumed, so the fetch stage can advance its byte pointer. After the pulse the decoder is ready for the next specifier byte.

Top module: `ea_decoder`

## Requirements
- R1: The specifier byte is split as mod = bits 7:6, reg = bits 5:3, rm = bits 2:0. With mod = 3 the operand is a register: `is_reg_o` = 1, `rm_idx_o` = rm, `ea_o` = 0, count = 1, and no more bytes are taken.
- R2: In 16-bit mode the memory base for rm 0..7 is BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, using the low 16 bits of slots 3 (BX), 5 (BP), 6 (SI) and 7 (DI). The one exception is mod = 0 with rm = 6, which uses no register and takes a 16-bit absolute displacement.
- R3: mod = 1 takes one displacement byte, sign-extended. mod = 2 takes 2 bytes in 16-bit mode and 4 bytes in 32-bit mode. Multi-byte displacements arrive least significant byte first.
- R4: In 16-bit mode the address is computed modulo 2^16, and `ea_o[31:16]` is 0.
- R5: In 32-bit mode without a scaled-index byte, the base is register slot rm. With mod = 0 and rm = 5 the address is a 4-byte absolute displacement, and no register is used.
- R6: In 32-bit mode, rm = 4 with mod 0..2 makes the next byte a scaled-index byte: scale = bits 7:6, index = bits 5:3, base = bits 2:0. The address is reg[base] + (reg[index] << scale) + displacement, modulo 2^32. The displacement length follows mod as in R3.
- R7: An index code of 4 adds no index term, whatever the scale.
- R8: A base code of 5 with mod = 0 replaces the base register with a 4-byte displacement. With mod = 1 or 2, base code 5 uses register slot 5 plus the mod displacement.
- R9: `done_o` is high for exactly one cycle, the cycle after the last addressing byte is accepted. `nbytes_o` equals the number of bytes accepted for that instruction (1 to 6). `byte_ready_o` is low only during the done cycle.
- R10: The addressing width is sampled together with the specifier byte. Register values are sampled in the cycle the last byte is accepted. `reg_field_o` reports the specifier's reg field.
- R11: While reset is asserted and right after it, `byte_ready_o` is 1 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| regs_i | input | 256 | General registers, slot k in bits 32k+31:32k |
| byte_valid_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Addressing byte |
| byte_ready_o | output | 1 | Decoder accepts a byte |
| done_o | output | 1 | One-cycle result strobe |
| is_reg_o | output | 1 | Operand is a register |
| rm_idx_o | output | 3 | rm field of the specifier |
| reg_field_o | output | 3 | reg field of the specifier |
| ea_o | output | 32 | Effective address |
| nbytes_o | output | 3 | Addressing bytes consumed |

## Verification
The bench aims at the encodings that hide a special meaning. It covers 16-bit rm 6 with mod 0, 32-bit rm 5 with mod 0, scaled-index base 5 with mod 0 against mod 1, and index code 4. A decoder that mishandles any of these adds a stray register or reads the wrong number of bytes, so the address and the count both come out wrong. Negative one-byte displacements and 16-bit sums that overflow check sign extension and wrap-around. A design that zero-extends, or keeps the carry out of bit 15, reports a high address. Some instructions change the width input after the specifier byte. A decoder that does not hold the width seen with that byte then expects the wrong number of bytes and computes the wrong address.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

  // register slots used by 16-bit addressing
  localparam logic [2:0] SLOT_BX = 3'd3;
  localparam logic [2:0] SLOT_BP = 3'd5;
  localparam logic [2:0] SLOT_SI = 3'd6;
  localparam logic [2:0] SLOT_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_e;
endpackage

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode32_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        byte_ready_o,
  output logic        fin_o,
  output logic        mode32_o,
  output logic [7:0]  modrm_o,
  output logic [7:0]  sib_o,
  output logic        has_sib_o,
  output logic [31:0] disp_o,
  output logic [2:0]  dlen_o,
  output logic [2:0]  nbytes_o
);
  ea_state_e   st_q;
  logic        mode_q, has_sib_q;
  logic [7:0]  modrm_q, sib_q;
  logic [31:0] disp_q;
  logic [1:0]  dcnt_q;
  logic [2:0]  dlen_q;

  logic        take, mode_c, sib_need, last_c, has_sib_c;
  logic [7:0]  modrm_c, sib_c;
  logic [1:0]  mod_c;
  logic [2:0]  rm_c, dlen_mr, dlen_sib, dlen_c;
  logic [31:0] disp_c;

  assign byte_ready_o = (st_q != ST_DONE);
  assign take         = byte_valid_i && byte_ready_o;

  always_comb begin
    mode_c   = (st_q == ST_MODRM) ? mode32_i : mode_q;
    modrm_c  = (st_q == ST_MODRM) ? byte_i : modrm_q;
    sib_c    = (st_q == ST_SIB) ? byte_i : sib_q;
    mod_c    = modrm_c[7:6];
    rm_c     = modrm_c[2:0];
    sib_need = mode_c && (mod_c != 2'd3) && (rm_c == 3'd4);

    unique case (mod_c)
      2'd0:    dlen_mr = mode_c ? ((rm_c == 3'd5) ? 3'd4 : 3'd0)
                                : ((rm_c == 3'd6) ? 3'd2 : 3'd0);
      2'd1:    dlen_mr = 3'd1;
      2'd2:    dlen_mr = mode_c ? 3'd4 : 3'd2;
      default: dlen_mr = 3'd0;
    endcase

    unique case (mod_c)
      2'd0:    dlen_sib = (sib_c[2:0] == 3'd5) ? 3'd4 : 3'd0;
      2'd1:    dlen_sib = 3'd1;
      default: dlen_sib = 3'd4;
    endcase

    disp_c = disp_q;
    if (st_q == ST_DISP) begin
      for (int k = 0; k < 4; k++) begin
        if (dcnt_q == k[1:0]) disp_c[8*k +: 8] = byte_i;
      end
    end

    unique case (st_q)
      ST_MODRM: begin
        last_c    = !sib_need && (dlen_mr == 3'd0);
        dlen_c    = sib_need ? 3'd0 : dlen_mr;
        has_sib_c = sib_need;
      end
      ST_SIB: begin
        last_c    = (dlen_sib == 3'd0);
        dlen_c    = dlen_sib;
        has_sib_c = has_sib_q;
      end
      ST_DISP: begin
        last_c    = ({1'b0, dcnt_q} + 3'd1) == dlen_q;
        dlen_c    = dlen_q;
        has_sib_c = has_sib_q;
      end
      default: begin
        last_c    = 1'b0;
        dlen_c    = dlen_q;
        has_sib_c = has_sib_q;
      end
    endcase
  end

  assign fin_o     = take && last_c;
  assign mode32_o  = mode_c;
  assign modrm_o   = modrm_c;
  assign sib_o     = sib_c;
  assign has_sib_o = has_sib_c;
  assign disp_o    = disp_c;
  assign dlen_o    = dlen_c;
  assign nbytes_o  = 3'd1 + {2'b00, has_sib_c} + dlen_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_MODRM;
      mode_q    <= 1'b0;
      has_sib_q <= 1'b0;
      modrm_q   <= '0;
      sib_q     <= '0;
      disp_q    <= '0;
      dcnt_q    <= '0;
      dlen_q    <= '0;
    end else begin
      unique case (st_q)
        ST_MODRM: if (take) begin
          modrm_q   <= byte_i;
          mode_q    <= mode32_i;
          has_sib_q <= sib_need;
          dlen_q    <= dlen_mr;
          dcnt_q    <= '0;
          disp_q    <= '0;
          st_q      <= last_c ? ST_DONE : (sib_need ? ST_SIB : ST_DISP);
        end
        ST_SIB: if (take) begin
          sib_q  <= byte_i;
          dlen_q <= dlen_sib;
          st_q   <= last_c ? ST_DONE : ST_DISP;
        end
        ST_DISP: if (take) begin
          disp_q <= disp_c;
          dcnt_q <= dcnt_q + 2'd1;
          if (last_c) st_q <= ST_DONE;
        end
        default: st_q <= ST_MODRM;
      endcase
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [NUM_REGS*ADDR_W-1:0] regs_i,
  input  logic                       mode32_i,
  input  logic [1:0]                 mod_i,
  input  logic [2:0]                 rm_i,
  input  logic                       has_sib_i,
  input  logic [7:0]                 sib_i,
  input  logic [31:0]                disp_i,
  input  logic [2:0]                 dlen_i,
  output logic                       is_reg_o,
  output logic [ADDR_W-1:0]          ea_o
);
  localparam int unsigned HALF_W = 16;

  logic [ADDR_W-1:0] r [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign r[g] = regs_i[g*ADDR_W +: ADDR_W];
  end

  logic [ADDR_W-1:0] disp_x, base32, idx32, sum32;
  logic [HALF_W-1:0] sum16;
  logic [1:0]        scale;
  logic [2:0]        idx_code, base_code;

  assign scale     = sib_i[7:6];
  assign idx_code  = sib_i[5:3];
  assign base_code = sib_i[2:0];

  always_comb begin
    unique case (dlen_i)
      3'd1:    disp_x = {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]};
      3'd2:    disp_x = {{(ADDR_W-16){1'b0}}, disp_i[15:0]};
      3'd4:    disp_x = disp_i[ADDR_W-1:0];
      default: disp_x = '0;
    endcase
  end

  always_comb begin
    unique case (rm_i)
      3'd0:    sum16 = r[SLOT_BX][15:0] + r[SLOT_SI][15:0];
      3'd1:    sum16 = r[SLOT_BX][15:0] + r[SLOT_DI][15:0];
      3'd2:    sum16 = r[SLOT_BP][15:0] + r[SLOT_SI][15:0];
      3'd3:    sum16 = r[SLOT_BP][15:0] + r[SLOT_DI][15:0];
      3'd4:    sum16 = r[SLOT_SI][15:0];
      3'd5:    sum16 = r[SLOT_DI][15:0];
      3'd6:    sum16 = (mod_i == 2'd0) ? '0 : r[SLOT_BP][15:0];
      default: sum16 = r[SLOT_BX][15:0];
    endcase
    sum16 = sum16 + disp_x[HALF_W-1:0];
  end

  always_comb begin
    if (has_sib_i) begin
      base32 = (mod_i == 2'd0 && base_code == 3'd5) ? '0 : r[base_code];
      idx32  = (idx_code == 3'd4) ? '0 : (r[idx_code] << scale);
    end else begin
      base32 = (mod_i == 2'd0 && rm_i == 3'd5) ? '0 : r[rm_i];
      idx32  = '0;
    end
    sum32 = base32 + idx32 + disp_x;
  end

  assign is_reg_o = (mod_i == 2'd3);
  assign ea_o     = is_reg_o ? '0
                  : (mode32_i ? sum32 : {{(ADDR_W-HALF_W){1'b0}}, sum16});
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mode32_i,
  input  logic [NUM_REGS*ADDR_W-1:0] regs_i,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  output logic                       byte_ready_o,
  output logic                       done_o,
  output logic                       is_reg_o,
  output logic [2:0]                 rm_idx_o,
  output logic [2:0]                 reg_field_o,
  output logic [ADDR_W-1:0]          ea_o,
  output logic [2:0]                 nbytes_o
);
  logic              fin, mode_c, has_sib;
  logic [7:0]        modrm, sib;
  logic [31:0]       disp;
  logic [2:0]        dlen, nbytes_c;
  logic              is_reg_c;
  logic [ADDR_W-1:0] ea_c;

  ea_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode32_i     (mode32_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .byte_ready_o (byte_ready_o),
    .fin_o        (fin),
    .mode32_o     (mode_c),
    .modrm_o      (modrm),
    .sib_o        (sib),
    .has_sib_o    (has_sib),
    .disp_o       (disp),
    .dlen_o       (dlen),
    .nbytes_o     (nbytes_c)
  );

  ea_calc #(.ADDR_W(ADDR_W)) u_calc (
    .regs_i    (regs_i),
    .mode32_i  (mode_c),
    .mod_i     (modrm[7:6]),
    .rm_i      (modrm[2:0]),
    .has_sib_i (has_sib),
    .sib_i     (sib),
    .disp_i    (disp),
    .dlen_i    (dlen),
    .is_reg_o  (is_reg_c),
    .ea_o      (ea_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      is_reg_o    <= 1'b0;
      rm_idx_o    <= '0;
      reg_field_o <= '0;
      ea_o        <= '0;
      nbytes_o    <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        is_reg_o    <= is_reg_c;
        rm_idx_o    <= modrm[2:0];
        reg_field_o <= modrm[5:3];
        ea_o        <= ea_c;
        nbytes_o    <= nbytes_c;
      end
    end
  end
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic              byte_ready_o,
  input logic              done_o,
  input logic              is_reg_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic [2:0]        nbytes_o
);
  logic [2:0] hs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hs_cnt <= '0;
    else if (done_o)                      hs_cnt <= '0;
    else if (byte_valid_i && byte_ready_o && hs_cnt != 3'd7) hs_cnt <= hs_cnt + 3'd1;
  end

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_stall_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o);
  a_r9_resume_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> byte_ready_o);
  a_r9_done_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(byte_valid_i && byte_ready_o));
  a_r9_count_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nbytes_o == hs_cnt));
  a_r9_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nbytes_o >= 3'd1 && nbytes_o <= 3'd6));
  a_r1_reg_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_reg_o) |-> (nbytes_o == 3'd1 && ea_o == '0));
endmodule

bind ea_decoder ea_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .done_o       (done_o),
  .is_reg_o     (is_reg_o),
  .ea_o         (ea_o),
  .nbytes_o     (nbytes_o)
);

// File: tb/sim_ea_decoder.sv
module sim_ea_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         m32 = 1'b1;
  logic [31:0]  rv [8];
  logic [255:0] regs_w;
  logic         vld = 1'b0;
  logic [7:0]   bi = 8'h00;
  logic         rdy, done, isreg;
  logic [2:0]   rmi, regf, nb;
  logic [31:0]  ea;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_pack
    assign regs_w[32*g +: 32] = rv[g];
  end

  ea_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(m32), .regs_i(regs_w),
    .byte_valid_i(vld), .byte_i(bi), .byte_ready_o(rdy), .done_o(done),
    .is_reg_o(isreg), .rm_idx_o(rmi), .reg_field_o(regf), .ea_o(ea),
    .nbytes_o(nb)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int disp_len(bit w32, logic [7:0] mr, logic [7:0] sb);
    logic [1:0] md = mr[7:6];
    logic [2:0] rm = mr[2:0];
    if (md == 2'd3) return 0;
    if (md == 2'd1) return 1;
    if (md == 2'd2) return w32 ? 4 : 2;
    if (!w32) return (rm == 3'd6) ? 2 : 0;
    if (rm == 3'd4) return (sb[2:0] == 3'd5) ? 4 : 0;
    return (rm == 3'd5) ? 4 : 0;
  endfunction

  function automatic logic [31:0] ref_ea(bit w32, logic [7:0] mr, logic [7:0] sb,
                                         logic [31:0] dv);
    logic [1:0]  md = mr[7:6];
    logic [2:0]  rm = mr[2:0];
    logic [15:0] bx = rv[3][15:0], bp = rv[5][15:0], si = rv[6][15:0], di = rv[7][15:0];
    logic [15:0] s16;
    logic [31:0] b, ix;
    if (md == 2'd3) return 32'h0;
    if (!w32) begin
      case (rm)
        3'd0: s16 = bx + si;
        3'd1: s16 = bx + di;
        3'd2: s16 = bp + si;
        3'd3: s16 = bp + di;
        3'd4: s16 = si;
        3'd5: s16 = di;
        3'd6: s16 = (md == 2'd0) ? 16'h0 : bp;
        default: s16 = bx;
      endcase
      s16 = s16 + dv[15:0];
      return {16'h0, s16};
    end
    if (rm == 3'd4) begin
      b  = (md == 2'd0 && sb[2:0] == 3'd5) ? 32'h0 : rv[sb[2:0]];
      ix = (sb[5:3] == 3'd4) ? 32'h0 : (rv[sb[5:3]] << sb[7:6]);
      return b + ix + dv;
    end
    if (md == 2'd0 && rm == 3'd5) return dv;
    return rv[rm] + dv;
  endfunction

  // flip: change the width input after the specifier byte (R10)
  task automatic run(bit w32, logic [7:0] mr, logic [7:0] sb, logic [31:0] draw,
                     bit flip, bit gaps, string tag);
    logic [7:0]  seq [6];
    int          n = 0;
    int          dl = disp_len(w32, mr, sb);
    bit          hs = w32 && mr[7:6] != 2'd3 && mr[2:0] == 3'd4;
    logic [31:0] dv;
    logic [31:0] exp_ea;
    seq[n++] = mr;
    if (hs) seq[n++] = sb;
    for (int k = 0; k < dl; k++) seq[n++] = draw[8*k +: 8];
    case (dl)
      1: dv = {{24{draw[7]}}, draw[7:0]};
      2: dv = {16'h0, draw[15:0]};
      4: dv = draw;
      default: dv = 32'h0;
    endcase
    exp_ea = ref_ea(w32, mr, sb, dv);
    @(negedge clk);
    m32 = w32;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (gaps) begin
        for (int gcnt = $urandom_range(0, 2); gcnt > 0; gcnt--) begin
          vld = 1'b0;
          @(negedge clk);
        end
      end
      for (int guard = 0; !rdy && guard < 20; guard++) @(negedge clk);
      vld = 1'b1;
      bi  = seq[i];
      @(posedge clk);
      if (i == 0 && flip) begin
        @(negedge clk);
        m32 = ~w32;
        vld = 1'b0;
        if (n > 1) begin
          // already at a negedge, continue at the next iteration without re-waiting
          for (int j = 1; j < n; j++) begin
            if (j > 1) @(negedge clk);
            vld = 1'b1;
            bi  = seq[j];
            @(posedge clk);
          end
        end
        i = n;
      end
    end
    if (flip && n == 1) begin
      // final byte already accepted, now at the done negedge
    end else begin
      @(negedge clk);
    end
    vld = 1'b0;
    chk({tag, " done pulse (R9)"}, {31'h0, done}, 32'h1);
    chk({tag, " ready low in done (R9)"}, {31'h0, rdy}, 32'h0);
    chk({tag, " byte count (R9)"}, {29'h0, nb}, n[31:0]);
    chk({tag, " register operand flag (R1)"}, {31'h0, isreg}, {31'h0, mr[7:6] == 2'd3});
    chk({tag, " address"}, ea, exp_ea);
    chk({tag, " rm field (R1)"}, {29'h0, rmi}, {29'h0, mr[2:0]});
    chk({tag, " reg field (R10)"}, {29'h0, regf}, {29'h0, mr[5:3]});
    @(negedge clk);
    chk({tag, " done drops (R9)"}, {31'h0, done}, 32'h0);
    chk({tag, " ready back (R9)"}, {31'h0, rdy}, 32'h1);
  endtask

  task automatic rand_regs();
    for (int k = 0; k < 8; k++) rv[k] = $urandom();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rand_regs();
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", {31'h0, rdy}, 32'h1);
    chk("R11 done in reset", {31'h0, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after reset", {31'h0, rdy}, 32'h1);
    chk("R11 done after reset", {31'h0, done}, 32'h0);

    run(1'b1, 8'hD3, 8'h00, 32'h0, 1'b0, 1'b0, "R1 reg operand");
    run(1'b0, 8'h06, 8'h00, 32'h0000_1234, 1'b0, 1'b0, "R2 abs16");
    rv[3] = 32'hABCD_FFF0; rv[6] = 32'h1234_0020;
    run(1'b0, 8'h00, 8'h00, 32'h0, 1'b0, 1'b0, "R4 wrap bx+si");
    rv[5] = 32'h0000_0100;
    run(1'b0, 8'h46, 8'h00, 32'h0000_0080, 1'b0, 1'b1, "R3 neg disp8 16b");
    run(1'b0, 8'h87, 8'h00, 32'h0000_FFFF, 1'b0, 1'b0, "R3 disp16 wrap");
    run(1'b1, 8'h05, 8'h00, 32'hDEAD_BEEF, 1'b0, 1'b1, "R5 abs32");
    run(1'b1, 8'h81, 8'h00, 32'h8000_0001, 1'b0, 1'b0, "R3 disp32 ecx");
    run(1'b1, 8'h04, 8'h88, 32'h0, 1'b0, 1'b0, "R6 eax+ecx*4");
    run(1'b1, 8'h04, 8'hE3, 32'h0, 1'b0, 1'b0, "R7 no index");
    run(1'b1, 8'h04, 8'h4D, 32'h0102_0304, 1'b0, 1'b1, "R8 base5 mod0");
    rv[5] = 32'h0000_1000;
    run(1'b1, 8'h44, 8'h25, 32'h0000_00F0, 1'b0, 1'b0, "R8 base5 mod1");
    run(1'b1, 8'h84, 8'hED, 32'h0000_0010, 1'b0, 1'b0, "R8 base5 mod2");
    run(1'b1, 8'h80, 8'h00, 32'h0000_0100, 1'b1, 1'b0, "R10 width held 32");
    run(1'b0, 8'h80, 8'h00, 32'h0000_0100, 1'b1, 1'b0, "R10 width held 16");

    for (int t = 0; t < 400; t++) begin
      bit          w = $urandom_range(0, 1) == 1;
      logic [7:0]  mr = 8'($urandom());
      logic [7:0]  sb = 8'($urandom());
      logic [31:0] d = $urandom();
      string       tg;
      rand_regs();
      if (mr[7:6] == 2'd3)      tg = "R1 rand";
      else if (!w)              tg = "R2 R4 rand";
      else if (mr[2:0] == 3'd4) tg = "R6 rand";
      else                      tg = "R5 rand";
      run(w, mr, sb, d, $urandom_range(0, 7) == 0, 1'b1, tg);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule